// File: doc/BRIEF.md
# Self-Checking Latin-Square Check-Bit Encoder

This block generates the check bits of a single-error-correcting code built on orthogonal Latin squares. It also watches its own output for faults. The data word is viewed as a square array of `SIDE` by `SIDE` bits, where the bit index is `SIDE*row + col`. One check bit is formed for each row and one for each column. With the default `SIDE` of 4, a 16-bit word yields 8 check bits.

Every data bit feeds exactly two check bits: its row bit and its column bit. The XOR of all check bits in a fault-free encoder is therefore always zero. A two-rail checker tests this predicted parity. One rail is the XOR of the row half of the check bits and the other rail is the XOR of the column half. Equal rails mean the codeword is trustworthy. Unequal rails flag a fault in the encoder or in the checker.

Each check bit is produced by its own XOR tree, so a fault on a single net can disturb only one check bit. A fault-inject mask flips chosen check-bit nets before they reach the outputs and the checker. This lets the detection path be exercised. A parameter selects whether the outputs are registered, with one cycle of latency and a synchronous reset, or purely combinational.

Top module: `ols_sc_encoder`

## Requirements
- R1: Check bit `row` (indices 0 to SIDE-1) is the XOR of data bits `SIDE*row` through `SIDE*row+SIDE-1`.
- R2: Check bit `SIDE+col` is the XOR of data bits `col`, `SIDE+col`, `2*SIDE+col`, and so on through the last row.
- R3: Inverting any single data bit changes exactly two check bits: one in the row half and one in the column half.
- R4: With an all-zero fault-inject mask, `rail_a_o` equals `rail_b_o` for every data word.
- R5: Setting any single bit of the fault-inject mask inverts that same bit of `check_o` and drives the rail pair to 01 or 10.
- R6: For any fault-inject mask, the rails differ exactly when the mask has an odd number of ones. Here `rail_a_o` is the XOR of check bits 0..SIDE-1 and `rail_b_o` is the XOR of check bits SIDE..2*SIDE-1.
- R7: With `REGISTER_OUT`=1, all outputs change only at a rising clock edge. They show the inputs present at that edge.
- R8: While `rst` is high at a rising edge, `data_o`, `check_o`, `rail_a_o` and `rail_b_o` are all cleared to zero.
- R9: `data_o` returns the data word unchanged, with the same latency as the check bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| data_i | input | SIDE*SIDE | Data word to encode |
| flip_i | input | 2*SIDE | Fault-inject mask, one bit per check-bit net |
| data_o | output | SIDE*SIDE | Data word aligned with the check bits |
| check_o | output | 2*SIDE | Check bits, row half low, column half high |
| rail_a_o | output | 1 | Parity of the row-half check bits |
| rail_b_o | output | 1 | Parity of the column-half check bits |

## Verification
The bench builds the block with `SIDE`=4 and `REGISTER_OUT`=1. At that size all 65,536 data words can be driven with a clean mask. The expected row and column bits and the rail equality are computed arithmetically for each word. The small check width also lets the bench apply all 256 fault-inject masks to several data words. This covers every single, double and odd-weight net corruption, as well as the one-cycle latency and reset behaviour of the registered variant.

// File: rtl/ols_enc_pkg.sv
package ols_enc_pkg;

   // number of check bits for a square of the given side
   function automatic int check_width(input int side);
      return 2 * side;
   endfunction

   // number of data bits for a square of the given side
   function automatic int data_width(input int side);
      return side * side;
   endfunction

   // two-rail indication from the parity checker
   typedef struct packed {
      logic a;
      logic b;
   } rail_pair_t;

endpackage

// File: rtl/ols_check_gen.sv
module ols_check_gen #(
   parameter int SIDE = 4
) (
   input  logic [SIDE*SIDE-1:0] data,
   output logic [2*SIDE-1:0]    chk
);
   localparam int DW = ols_enc_pkg::data_width(SIDE);
   localparam int CW = ols_enc_pkg::check_width(SIDE);

   initial begin
      if (SIDE < 2) $error("ols_check_gen: SIDE must be at least 2");
      if (DW != SIDE*SIDE || CW != 2*SIDE) $error("ols_check_gen: width mismatch");
   end

   // each check bit owns a private XOR tree; no gate is shared between bits
   for (genvar g = 0; g < SIDE; g++) begin : g_row
      logic acc;
      always_comb begin
         acc = 1'b0;
         for (int c = 0; c < SIDE; c++) acc = acc ^ data[SIDE*g + c];
      end
      assign chk[g] = acc;
   end

   for (genvar g = 0; g < SIDE; g++) begin : g_col
      logic acc;
      always_comb begin
         acc = 1'b0;
         for (int r = 0; r < SIDE; r++) acc = acc ^ data[SIDE*r + g];
      end
      assign chk[SIDE + g] = acc;
   end

endmodule

// File: rtl/ols_rail_checker.sv
module ols_rail_checker #(
   parameter int N = 8
) (
   input  logic [N-1:0]              bits,
   output ols_enc_pkg::rail_pair_t   pair
);
   localparam int HALF = N / 2;

   initial begin
      if (N < 2 || (N % 2) != 0) $error("ols_rail_checker: N must be even and >= 2");
   end

   // two disjoint parity trees: low half and high half
   logic lo_par, hi_par;
   always_comb begin
      lo_par = 1'b0;
      for (int i = 0; i < HALF; i++) lo_par = lo_par ^ bits[i];
   end
   always_comb begin
      hi_par = 1'b0;
      for (int i = HALF; i < N; i++) hi_par = hi_par ^ bits[i];
   end

   assign pair.a = lo_par;
   assign pair.b = hi_par;

endmodule

// File: rtl/ols_out_stage.sv
module ols_out_stage #(
   parameter int W            = 26,
   parameter bit REGISTER_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      if (W < 1) $error("ols_out_stage: W must be positive");
   end

   if (REGISTER_OUT) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
         if (rst) q_r <= '0;
         else     q_r <= d;
      end
      assign q = q_r;
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst;
      assign q = d;
   end

endmodule

// File: rtl/ols_sc_encoder.sv
module ols_sc_encoder #(
   parameter int SIDE         = 4,
   parameter bit REGISTER_OUT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [SIDE*SIDE-1:0] data_i,
   input  logic [2*SIDE-1:0]    flip_i,
   output logic [SIDE*SIDE-1:0] data_o,
   output logic [2*SIDE-1:0]    check_o,
   output logic                 rail_a_o,
   output logic                 rail_b_o
);
   localparam int DW = ols_enc_pkg::data_width(SIDE);
   localparam int CW = ols_enc_pkg::check_width(SIDE);
   localparam int SW = DW + CW + 2;

   initial begin
      if (SIDE < 2) $error("ols_sc_encoder: SIDE must be at least 2");
   end

   logic [CW-1:0]            chk_clean;
   logic [CW-1:0]            chk_net;
   ols_enc_pkg::rail_pair_t  pair;
   logic [SW-1:0]            stage_d, stage_q;

   ols_check_gen #(.SIDE(SIDE)) u_gen (
      .data (data_i),
      .chk  (chk_clean)
   );

   // injected faults act on the check-bit nets seen by outputs and checker
   assign chk_net = chk_clean ^ flip_i;

   ols_rail_checker #(.N(CW)) u_chk (
      .bits (chk_net),
      .pair (pair)
   );

   assign stage_d = {data_i, chk_net, pair.a, pair.b};

   ols_out_stage #(.W(SW), .REGISTER_OUT(REGISTER_OUT)) u_stage (
      .clk (clk),
      .rst (rst),
      .d   (stage_d),
      .q   (stage_q)
   );

   assign {data_o, check_o, rail_a_o, rail_b_o} = stage_q;

   if (REGISTER_OUT) begin : g_chk_reg
      AST_CLEAN_RAILS_EQUAL: assert property (@(posedge clk) disable iff (rst)
         (flip_i == '0) |=> (rail_a_o == rail_b_o)); // R4
      AST_SINGLE_FLIP_SEEN: assert property (@(posedge clk) disable iff (rst)
         $onehot(flip_i) |=> (rail_a_o != rail_b_o)); // R5
      AST_EVEN_FLIP_MASKED: assert property (@(posedge clk) disable iff (rst)
         (($countones(flip_i) % 2) == 0) |=> (rail_a_o == rail_b_o)); // R6
      AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
         1'b1 |=> (data_o == $past(data_i))); // R9
   end

endmodule

// File: tb/ols_sc_encoder_tb.sv
module ols_sc_encoder_tb;
   localparam int SIDE = 4;
   localparam int DW   = SIDE*SIDE;
   localparam int CW   = 2*SIDE;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] data_i = '0;
   logic [CW-1:0] flip_i = '0;
   logic [DW-1:0] data_o;
   logic [CW-1:0] check_o;
   logic          rail_a_o, rail_b_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   ols_sc_encoder #(.SIDE(SIDE), .REGISTER_OUT(1'b1)) u_dut (
      .clk(clk), .rst(rst), .data_i(data_i), .flip_i(flip_i),
      .data_o(data_o), .check_o(check_o), .rail_a_o(rail_a_o), .rail_b_o(rail_b_o)
   );

   function automatic logic [CW-1:0] ref_chk(input logic [DW-1:0] d);
      logic [CW-1:0] c = '0;
      for (int r = 0; r < SIDE; r++)
         for (int k = 0; k < SIDE; k++) begin
            c[r]      = c[r]      ^ d[SIDE*r + k];
            c[SIDE+k] = c[SIDE+k] ^ d[SIDE*r + k];
         end
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // verify outputs against inputs d,f captured at the previous edge
   task automatic verify(input logic [DW-1:0] d, input logic [CW-1:0] f);
      logic [CW-1:0] e;
      logic ea, eb;
      e  = ref_chk(d) ^ f;
      ea = ^e[SIDE-1:0];
      eb = ^e[CW-1:SIDE];
      check(check_o[SIDE-1:0] == e[SIDE-1:0], "R1 row bits", 32'(check_o[SIDE-1:0]), 32'(e[SIDE-1:0]));
      check(check_o[CW-1:SIDE] == e[CW-1:SIDE], "R2 column bits", 32'(check_o[CW-1:SIDE]), 32'(e[CW-1:SIDE]));
      check({rail_a_o, rail_b_o} == {ea, eb}, "R6 rail pair", 32'({rail_a_o, rail_b_o}), 32'({ea, eb}));
      check(data_o == d, "R9 data pass", 32'(data_o), 32'(d));
      if (f == '0)
         check(rail_a_o == rail_b_o, "R4 clean rails equal", 32'({rail_a_o, rail_b_o}), 32'({ea, ea}));
      if ($countones(f) == 1)
         check(rail_a_o != rail_b_o, "R5 single flip detected", 32'({rail_a_o, rail_b_o}), 32'({ea, ~ea}));
   endtask

   initial begin : wdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [DW-1:0] pd;
      logic [CW-1:0] pf;
      logic [CW-1:0] base_c;
      // R8: reset clears everything despite busy inputs
      @(negedge clk); data_i = '1; flip_i = '1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check({data_o, check_o, rail_a_o, rail_b_o} == '0, "R8 reset clears", 32'({data_o, check_o}), 32'h0);
      rst = 1'b0;

      // exhaustive clean sweep (R1, R2, R4, R9)
      data_i = '0; flip_i = '0; pd = '0; pf = '0;
      for (int v = 1; v <= 65536; v++) begin
         @(negedge clk);
         verify(pd, pf);
         pd = DW'(v); data_i = pd;
      end

      // R3: single data-bit inversion moves one row and one column bit
      for (int i = 0; i < DW; i++) begin
         @(negedge clk); data_i = 16'hA5C3; flip_i = '0;
         @(negedge clk); base_c = check_o; data_i = 16'hA5C3 ^ (16'h1 << i);
         @(negedge clk);
         check($countones(base_c ^ check_o) == 2 && $countones((base_c ^ check_o) & 8'h0F) == 1,
               "R3 two check bits change", 32'(base_c ^ check_o), 32'(ref_chk(16'hA5C3) ^ ref_chk(16'hA5C3 ^ (16'h1 << i))));
      end

      // all fault masks on several words (R5, R6)
      for (int w = 0; w < 4; w++) begin
         @(negedge clk);
         pd = (w == 0) ? 16'h0000 : (w == 1) ? 16'hFFFF : (w == 2) ? 16'h1234 : 16'h8E71;
         pf = '0; data_i = pd; flip_i = pf;
         for (int m = 1; m <= 256; m++) begin
            @(negedge clk);
            verify(pd, pf);
            check((rail_a_o ^ rail_b_o) == ($countones(pf) % 2), "R6 parity of mask", 32'(rail_a_o ^ rail_b_o), 32'($countones(pf) % 2));
            pf = CW'(m); flip_i = pf;
         end
      end

      // R7: a new input does not reach the outputs before the edge
      @(negedge clk); data_i = 16'h00F0; flip_i = '0;
      @(negedge clk); data_i = 16'h0F0F;
      #1 check(data_o == 16'h00F0, "R7 holds until edge", 32'(data_o), 32'h00F0);
      @(negedge clk);
      check(data_o == 16'h0F0F && check_o == ref_chk(16'h0F0F), "R7 updates at edge", 32'(data_o), 32'h0F0F);

      // R8: reset in mid-run
      data_i = 16'h7777; flip_i = 8'h01; rst = 1'b1;
      @(negedge clk);
      check({data_o, check_o, rail_a_o, rail_b_o} == '0, "R8 mid-run reset", 32'({data_o, check_o}), 32'h0);
      rst = 1'b0;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule